// File: doc/BRIEF.md
# Slot Fraction Metrics Unit

The unit watches how a core's issue slots are spent. Each cycle it takes a 3-bit count of slots issued. It also takes one 3-bit count for each of four categories: retiring, bad speculation, frontend bound and backend bound. Each category count goes into a category counter that software can neither read nor load. The slots count goes into a slots counter that software can write. That slots counter is the denominator for every ratio the unit reports.

Software reaches the unit through a small request port. Select value 0 addresses the slots counter and select value 1 addresses the packed metrics word. A read of the metrics word freezes all counters and computes one 8-bit fraction per category with a shared sequential divider. The unit then returns the packed word with a single read-valid pulse and clears every counter. A read of the slots counter returns its value and clears it. Writing the metrics word zeroes the category counters. A sticky flag records that a category counter has wrapped.

Top module: `slot_metrics_unit`

## Requirements
- R1: After synchronous reset, rvalid, busy and ovf_flag are 0, and all counters are zero: a slots read returns 0 and a metrics read returns 0.
- R2: While idle, each cycle the slots counter adds slot_inc, and category lane k adds cat_inc[3k+2:3k] (lane 0 retiring, 1 bad speculation, 2 frontend bound, 3 backend bound). All counters wrap modulo 2^CNT_W.
- R3: The metrics word carries, for each category with count c and slots count s (0 < c < s), the value floor(255*c/s). Retiring sits in bits [7:0], bad speculation in [15:8], frontend bound in [23:16] and backend bound in [31:24]. All higher bits are 0.
- R4: A field whose category count is greater than or equal to a nonzero slots count reads 0xFF.
- R5: When the slots count is zero at the read request, all four fields read 0.
- R6: A metrics read (req_valid=1, req_write=0, req_sel=1) raises busy from the request edge until the result. Increments arriving during that time are dropped. The result arrives as a one-cycle rvalid pulse, and busy is low whenever rvalid is high.
- R7: After a metrics read completes, the slots counter and all category counters are zero.
- R8: A slots read (req_sel=0) returns the slots count on rdata with rvalid in the next cycle. It clears the slots counter and leaves the category counters unchanged.
- R9: A slots write loads wdata into the slots counter and leaves the category counters unchanged.
- R10: A metrics write zeroes all category counters, ignores wdata and leaves the slots counter unchanged.
- R11: ovf_flag rises when any category counter wraps. It stays set until ovf_clear is pulsed.
- R12: Requests presented while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_inc | input | INC_W | Slots issued this cycle |
| cat_inc | input | NCAT*INC_W | Per-category slot counts, lane 0 retiring, up to lane 3 backend bound |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_sel | input | 1 | 0 slots counter, 1 metrics word |
| wdata | input | DATA_W | Write data |
| ovf_clear | input | 1 | Clears the overflow flag |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | Read data valid pulse |
| busy | output | 1 | Fraction computation in progress |
| ovf_flag | output | 1 | Sticky category-counter wrap flag |

## Verification
The bench aims at the boundaries of the division. It covers a category equal to the slots count, which must give 0xFF rather than a wrapped quotient. It covers a zero slots count with nonzero categories, where a divider run without the guard would return all ones. It covers a large preset slots value, which must collapse the fractions toward zero. It also drives increments and a stray write while the unit is busy. A design that failed to freeze its counters would then report fractions that include those slots, or would leave a nonzero slots count after the read. The overflow flag is checked just before and just after a wrap and again after more counting, so a flag that is not sticky or that is raised early is caught. Slots reads and writes are placed between category counting and a later metrics read. A design that disturbed the hidden counters on those accesses would return wrong fractions.

// File: rtl/slotm_pkg.sv
`timescale 1ns/1ps
package slotm_pkg;
    localparam int NCAT   = 4;
    localparam int FRAC_W = 8;

    typedef enum logic [1:0] {
        CAT_RETIRE   = 2'd0,
        CAT_BADSPEC  = 2'd1,
        CAT_FRONTEND = 2'd2,
        CAT_BACKEND  = 2'd3
    } cat_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_CALC = 1'b1
    } ctl_e;

    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_LOAD = 2'd1,
        DIV_STEP = 2'd2
    } div_e;

    typedef struct packed {
        logic start;
        logic rd_slots;
        logic wr_slots;
        logic wr_metrics;
    } access_t;

    function automatic access_t decode_access(logic v, logic w, logic sel, logic idle);
        access_t a;
        logic ok;
        ok           = v & idle;
        a.start      = ok & ~w & sel;
        a.rd_slots   = ok & ~w & ~sel;
        a.wr_slots   = ok & w & ~sel;
        a.wr_metrics = ok & w & sel;
        return a;
    endfunction
endpackage

// File: rtl/slotm_counters.sv
`timescale 1ns/1ps
module slotm_counters #(
    parameter int CNT_W = 48,
    parameter int INC_W = 3,
    parameter int NCAT  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold,
    input  logic                  load_slots,
    input  logic [CNT_W-1:0]      load_val,
    input  logic                  clear_slots,
    input  logic                  clear_cats,
    input  logic [INC_W-1:0]      slot_inc,
    input  logic [NCAT*INC_W-1:0] cat_inc,
    output logic [CNT_W-1:0]      slots,
    output logic [NCAT*CNT_W-1:0] cats,
    output logic                  wrap_any
);
    logic [NCAT-1:0] wrap_lane;

    always_ff @(posedge clk) begin
        if (rst)              slots <= '0;
        else if (clear_slots) slots <= '0;
        else if (load_slots)  slots <= load_val;
        else if (!hold)       slots <= slots + CNT_W'(slot_inc);
    end

    for (genvar k = 0; k < NCAT; k++) begin : g_lane
        logic [CNT_W:0] sum;
        assign sum = {1'b0, cats[k*CNT_W +: CNT_W]} + (CNT_W+1)'(cat_inc[k*INC_W +: INC_W]);
        assign wrap_lane[k] = sum[CNT_W] & ~hold & ~clear_cats;

        always_ff @(posedge clk) begin
            if (rst)             cats[k*CNT_W +: CNT_W] <= '0;
            else if (clear_cats) cats[k*CNT_W +: CNT_W] <= '0;
            else if (!hold)      cats[k*CNT_W +: CNT_W] <= sum[CNT_W-1:0];
        end
    end

    assign wrap_any = |wrap_lane;

    // R6: counters frozen while held
    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear_slots && !clear_cats && !load_slots) |=> ($stable(slots) && $stable(cats)));

    // R9: a slots load leaves the categories alone
    assert_load_keeps_cats_R9: assert property (@(posedge clk) disable iff (rst)
        (load_slots && hold && !clear_cats) |=> $stable(cats));
endmodule

// File: rtl/slotm_divider.sv
`timescale 1ns/1ps
module slotm_divider
    import slotm_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int NCAT_P = 4,
    parameter int FR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NCAT_P*CNT_W-1:0] cats,
    input  logic [CNT_W-1:0]        den,
    output logic                    done,
    output logic [NCAT_P*FR_W-1:0]  word
);
    localparam int NUM_W = CNT_W + FR_W;
    localparam int IDX_W = (NCAT_P > 1) ? $clog2(NCAT_P) : 1;
    localparam int BIT_W = $clog2(FR_W);

    div_e              st;
    logic [CNT_W-1:0]  snap [NCAT_P];
    logic [CNT_W-1:0]  den_q;
    logic [IDX_W-1:0]  idx;
    logic [BIT_W-1:0]  bitc;
    logic [NUM_W-1:0]  rem;
    logic [NUM_W-1:0]  dsh;
    logic [FR_W-1:0]   q;
    logic [FR_W-1:0]   res [NCAT_P];
    logic              sat_q;
    logic              zero_q;
    logic              ge;
    logic [FR_W-1:0]   q_next;

    assign ge     = (rem >= dsh);
    assign q_next = {q[FR_W-2:0], ge};

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= DIV_IDLE;
            done   <= 1'b0;
            den_q  <= '0;
            idx    <= '0;
            bitc   <= '0;
            rem    <= '0;
            dsh    <= '0;
            q      <= '0;
            sat_q  <= 1'b0;
            zero_q <= 1'b0;
            for (int k = 0; k < NCAT_P; k++) begin
                snap[k] <= '0;
                res[k]  <= '0;
            end
        end else begin
            done <= 1'b0;
            case (st)
                DIV_IDLE: if (start) begin
                    for (int k = 0; k < NCAT_P; k++) snap[k] <= cats[k*CNT_W +: CNT_W];
                    den_q <= den;
                    idx   <= '0;
                    st    <= DIV_LOAD;
                end
                DIV_LOAD: begin
                    rem    <= NUM_W'({snap[idx], {FR_W{1'b0}}}) - NUM_W'(snap[idx]);
                    dsh    <= NUM_W'(den_q) << (FR_W - 1);
                    bitc   <= BIT_W'(FR_W - 1);
                    q      <= '0;
                    zero_q <= (den_q == '0);
                    sat_q  <= (snap[idx] >= den_q);
                    st     <= DIV_STEP;
                end
                default: begin
                    if (ge) rem <= rem - dsh;
                    dsh  <= dsh >> 1;
                    q    <= q_next;
                    bitc <= bitc - 1'b1;
                    if (bitc == '0) begin
                        res[idx] <= zero_q ? '0 : (sat_q ? {FR_W{1'b1}} : q_next);
                        if (idx == IDX_W'(NCAT_P - 1)) begin
                            done <= 1'b1;
                            st   <= DIV_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= DIV_LOAD;
                        end
                    end
                end
            endcase
        end
    end

    for (genvar k = 0; k < NCAT_P; k++) begin : g_pack
        assign word[k*FR_W +: FR_W] = res[k];
    end

    // R3: restoring invariant, the quotient always fits the field
    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (st == DIV_STEP && !zero_q && !sat_q) |-> (rem < (dsh << 1)));

    // R6: a new start is never seen while a computation runs
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (st != DIV_IDLE) |-> !start);
endmodule

// File: rtl/slot_metrics_unit.sv
`timescale 1ns/1ps
module slot_metrics_unit
    import slotm_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int INC_W  = 3,
    parameter int DATA_W = (CNT_W > NCAT*FRAC_W) ? CNT_W : NCAT*FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [INC_W-1:0]      slot_inc,
    input  logic [NCAT*INC_W-1:0] cat_inc,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  ovf_clear,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rvalid,
    output logic                  busy,
    output logic                  ovf_flag
);
    ctl_e                  st;
    access_t               acc;
    logic                  div_done;
    logic [NCAT*FRAC_W-1:0] div_word;
    logic [CNT_W-1:0]      slots;
    logic [NCAT*CNT_W-1:0] cats;
    logic                  wrap_any;
    logic                  hold;
    logic                  met_done_q;
    logic                  wr_met_q;

    assign acc  = decode_access(req_valid, req_write, req_sel, st == CTL_IDLE);
    assign busy = (st == CTL_CALC);
    assign hold = acc.start | busy;

    slotm_counters #(.CNT_W(CNT_W), .INC_W(INC_W), .NCAT(NCAT)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .load_slots (acc.wr_slots),
        .load_val   (wdata[CNT_W-1:0]),
        .clear_slots(acc.rd_slots | div_done),
        .clear_cats (acc.wr_metrics | div_done),
        .slot_inc   (slot_inc),
        .cat_inc    (cat_inc),
        .slots      (slots),
        .cats       (cats),
        .wrap_any   (wrap_any)
    );

    slotm_divider #(.CNT_W(CNT_W), .NCAT_P(NCAT), .FR_W(FRAC_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .start(acc.start),
        .cats (cats),
        .den  (slots),
        .done (div_done),
        .word (div_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= CTL_IDLE;
            rvalid     <= 1'b0;
            rdata      <= '0;
            ovf_flag   <= 1'b0;
            met_done_q <= 1'b0;
            wr_met_q   <= 1'b0;
        end else begin
            if (acc.start)     st <= CTL_CALC;
            else if (div_done) st <= CTL_IDLE;
            rvalid     <= acc.rd_slots | div_done;
            met_done_q <= div_done;
            wr_met_q   <= acc.wr_metrics;
            if (div_done)          rdata <= DATA_W'(div_word);
            else if (acc.rd_slots) rdata <= DATA_W'(slots);
            ovf_flag <= (ovf_flag & ~ovf_clear) | wrap_any;
        end
    end

    // R6: result never presented while still computing
    assert_busy_no_valid_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rvalid);

    // R11: the flag holds until cleared
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clear) |=> ovf_flag);

    // R7: everything zero right after a metrics result
    assert_clear_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        met_done_q |-> (slots == '0 && cats == '0));

    // R10: category counters zero after a metrics write
    assert_wr_clears_R10: assert property (@(posedge clk) disable iff (rst)
        wr_met_q |-> (cats == '0));
endmodule

// File: tb/sim_slot_metrics_unit.sv
`timescale 1ns/1ps
module sim_slot_metrics_unit;
    localparam int CW   = 12;
    localparam int DW   = 32;
    localparam int MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    slot_inc = '0;
    logic [11:0]   cat_inc = '0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          ovf_clear = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid, busy, ovf_flag;

    int checks = 0;
    int errors = 0;
    int unsigned m_slots;
    int unsigned m_cat [4];
    bit m_ovf;

    always #2.5 clk = ~clk;

    slot_metrics_unit #(.CNT_W(CW), .INC_W(3)) u0 (
        .clk(clk), .rst(rst), .slot_inc(slot_inc), .cat_inc(cat_inc),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .wdata(wdata), .ovf_clear(ovf_clear), .rdata(rdata), .rvalid(rvalid),
        .busy(busy), .ovf_flag(ovf_flag)
    );

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int unsigned frac(int unsigned c, int unsigned s);
        if (s == 0) return 0;
        if (c >= s) return 255;
        return (255 * c) / s;
    endfunction

    function automatic logic [31:0] exp_word();
        return {8'(frac(m_cat[3], m_slots)), 8'(frac(m_cat[2], m_slots)),
                8'(frac(m_cat[1], m_slots)), 8'(frac(m_cat[0], m_slots))};
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(logic [2:0] si, logic [2:0] c0, logic [2:0] c1, logic [2:0] c2, logic [2:0] c3);
        int unsigned ci [4];
        ci = '{c0, c1, c2, c3};
        @(negedge clk);
        slot_inc = si;
        cat_inc  = {c3, c2, c1, c0};
        @(posedge clk);
        m_slots = (m_slots + si) & MASK;
        for (int k = 0; k < 4; k++) begin
            if (m_cat[k] + ci[k] > MASK) m_ovf = 1;
            m_cat[k] = (m_cat[k] + ci[k]) & MASK;
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        slot_inc = '0;
        cat_inc  = '0;
    endtask

    task automatic rand_steps(int n);
        for (int i = 0; i < n; i++)
            step(3'($urandom % 8), 3'($urandom % 4), 3'($urandom % 3),
                 3'($urandom % 3), 3'($urandom % 2));
        quiet();
    endtask

    task automatic read_metrics(string req);
        logic [31:0] exp;
        int w;
        exp = exp_word();
        quiet();
        req_valid = 1; req_write = 0; req_sel = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1'b1, "R6 busy after metrics request", busy, 1);
        w = 0;
        while (!rvalid && w < 100) begin
            slot_inc = 3'($urandom % 8);
            cat_inc  = 12'($urandom);
            if (w == 0) begin
                req_valid = 1; req_write = 1; req_sel = 0; wdata = 32'd99;
            end else begin
                req_valid = 0;
            end
            @(negedge clk);
            w++;
        end
        req_valid = 0;
        slot_inc = '0;
        cat_inc  = '0;
        chk(rvalid == 1'b1 && busy == 1'b0, "R6 result valid, not busy", rvalid, 1);
        chk(rdata == DW'(exp), req, rdata, exp);
        m_slots = 0;
        for (int k = 0; k < 4; k++) m_cat[k] = 0;
        chk(ovf_flag == m_ovf, "R11 flag after metrics read", ovf_flag, m_ovf);
        @(negedge clk);
        chk(rvalid == 1'b0, "R6 one-cycle valid pulse", rvalid, 0);
    endtask

    task automatic read_slots(string req);
        quiet();
        req_valid = 1; req_write = 0; req_sel = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(rvalid == 1'b1 && rdata == DW'(m_slots), req, rdata, m_slots);
        m_slots = 0;
    endtask

    task automatic write_slots(int unsigned v);
        quiet();
        req_valid = 1; req_write = 1; req_sel = 0; wdata = DW'(v);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        m_slots = v & MASK;
    endtask

    task automatic write_metrics();
        quiet();
        req_valid = 1; req_write = 1; req_sel = 1; wdata = $urandom;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 4; k++) m_cat[k] = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        m_slots = 0; m_ovf = 0;
        for (int k = 0; k < 4; k++) m_cat[k] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(rvalid == 0 && busy == 0 && ovf_flag == 0, "R1 reset outputs", {rvalid, busy, ovf_flag}, 0);
        read_slots("R1 slots zero after reset");
        read_metrics("R1 metrics zero after reset");

        // R2 counting, then R8 slots read keeps categories, R9 write
        for (int i = 0; i < 10; i++) step(3'd3, 3'd1, 3'd2, 3'd0, 3'd1);
        read_slots("R2 slots accumulate / R8 slots read");
        read_slots("R8 slots cleared by read");
        write_slots(100);
        read_metrics("R3 fractions after R8/R9 slots access");

        // R5 zero denominator
        for (int i = 0; i < 6; i++) step(3'd0, 3'd2, 3'd1, 3'd3, 3'd1);
        read_metrics("R5 zero slots gives zero fields");

        // R4 saturation, including equality
        for (int i = 0; i < 5; i++) step(3'd1, 3'd7, 3'd5, 3'd1, 3'd0);
        read_metrics("R4 saturate at count >= slots");
        read_slots("R7 slots zero after metrics read");

        // R10 metrics write clears categories only
        for (int i = 0; i < 8; i++) step(3'd5, 3'd4, 3'd4, 3'd4, 3'd4);
        write_metrics();
        for (int i = 0; i < 3; i++) step(3'd2, 3'd0, 3'd0, 3'd0, 3'd0);
        read_slots("R10 slots kept by metrics write");
        write_slots(50);
        read_metrics("R10 categories zero after metrics write");

        // large preset collapses fractions
        write_slots(4000);
        for (int i = 0; i < 3; i++) step(3'd0, 3'd7, 3'd7, 3'd7, 3'd7);
        read_metrics("R3 large preset denominator");

        // R11 overflow flag
        for (int i = 0; i < 500; i++) step(3'd0, 3'd0, 3'd0, 3'd7, 3'd0);
        quiet();
        chk(ovf_flag == 1'b0, "R11 no flag before wrap", ovf_flag, 0);
        for (int i = 0; i < 100; i++) step(3'd0, 3'd0, 3'd0, 3'd7, 3'd0);
        quiet();
        chk(ovf_flag == 1'b1, "R11 flag after wrap", ovf_flag, 1);
        repeat (5) @(negedge clk);
        chk(ovf_flag == 1'b1, "R11 flag sticky", ovf_flag, 1);
        ovf_clear = 1;
        @(negedge clk);
        ovf_clear = 0;
        m_ovf = 0;
        chk(ovf_flag == 1'b0, "R11 flag cleared", ovf_flag, 0);
        write_metrics();
        write_slots(0);

        // random mix, R3 R12 via read_metrics
        for (int it = 0; it < 30; it++) begin
            int op;
            rand_steps(5 + int'($urandom % 40));
            op = int'($urandom % 4);
            if (op < 2)       read_metrics("R3 random metrics read / R12");
            else if (op == 2) read_slots("R8 random slots read");
            else              write_slots($urandom % 300);
        end
        read_metrics("R7 final metrics read");
        read_slots("R7 final slots zero");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule